// File: doc/BRIEF.md
# Video Gain, Offset and Legal-Range Clipper

This block sits in a component video path. It carries a 10-bit 4:2:2 sample stream in which each sample is marked as luma or chroma. Each picture sample is scaled by a per-component gain about a fixed pivot code. A per-component signed offset is then added, and the result is hard-clipped to one of two windows. With legalizing on, the window is the legal video range. With legalizing off, the window only keeps the reserved timing codes out of the picture. Samples flagged as timing reference or ancillary payload, such as embedded audio, leave the block exactly as they entered.

Every gain, offset and window control is captured together with the sample it applies to. Settings can therefore change on any cycle without disturbing samples already in flight. The pipeline has three register stages: multiply, add and round, then clip. Valid and the sample flags are delayed by the same three cycles, so the output stream keeps the same cadence as the input.

Top module: `vproc_gain_clip`

## Requirements
- R1: `out_valid`, `out_chroma` and `out_anc` repeat `in_valid`, `in_chroma` and `in_anc` exactly three rising clock edges later. `out_valid` is 0 while `rst_n` is low and on the first edge after reset is released.
- R2: For a luma sample (`in_chroma`=0, `in_anc`=0) the pivot is 64. With `d` = sample − 64 and gain code `G` (8192 = unity, range 0..32767), the scaled value in quarter codes is `q` = round(`d`·`G`/2048). A unity gain with zero offset returns any in-window sample unchanged.
- R3: For a chroma sample (`in_chroma`=1) the same arithmetic is applied about the pivot 512, using `chroma_gain`.
- R4: Offsets are two's complement in quarter-code units: `luma_ofs` is 13 bits (−4095..4095) and `chroma_ofs` is 12 bits (−2047..2047). The offset is added to `q`, the sum `t` is turned back into whole codes as round(`t`/4), and the pivot is added back.
- R5: Both rounding steps resolve an exact half upward, toward +infinity. For example, +1.5 becomes 2 and −1.5 becomes −1.
- R6: With `legal_en`=1, processed luma is clipped to 64..940 (040h..3ACh).
- R7: With `legal_en`=1, processed chroma is clipped to 64..960 (040h..3C0h).
- R8: With `legal_en`=0, processed luma and chroma are both clipped to 4..1019 (004h..3FBh). No processed sample ever leaves that window.
- R9: A sample with `in_anc`=1 is output unchanged, whatever the gains, offsets and `legal_en`.
- R10: A luma sample is not affected by `chroma_gain` or `chroma_ofs`, and a chroma sample is not affected by `luma_gain` or `luma_ofs`.
- R11: The gains, offsets and `legal_en` applied to a sample are those present in the cycle the sample is presented. Changing them in later cycles does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 10 | Input sample code |
| in_chroma | input | 1 | 1 = Cb/Cr sample, 0 = Y sample |
| in_anc | input | 1 | 1 = timing/ancillary word, pass unchanged |
| luma_gain | input | 15 | Luma gain, 8192 = unity |
| chroma_gain | input | 15 | Chroma gain, 8192 = unity |
| luma_ofs | input | 13 | Signed luma offset, quarter codes |
| chroma_ofs | input | 12 | Signed chroma offset, quarter codes |
| legal_en | input | 1 | 1 = legal-range clip, 0 = reserved-code clip only |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 10 | Processed sample code |
| out_chroma | output | 1 | Delayed component flag |
| out_anc | output | 1 | Delayed ancillary flag |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 15-bit gains with unity at 8192, quarter-code offsets of 13 and 12 bits, and the legal and reserved windows given above. With these values, the full gain span from zero to just under four times, the most negative and most positive offsets, and exact half-step products are all reachable in a single sample each. A streamed sequence with gaps in valid, mixed ancillary words, and controls that change every cycle shows the control alignment and the three-cycle delay together.

// File: rtl/vproc_pkg.sv
package vproc_pkg;

  // Per-sample side information carried down the pipeline.
  typedef struct packed {
    logic valid;
    logic chroma;
    logic anc;
    logic legal;
  } vp_tag_t;

  // Arithmetic shift right by sh with an exact half rounded upward.
  function automatic longint rnd_shr(longint v, int sh);
    if (sh <= 0) return v;
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // Saturate v into [lo, hi].
  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Pivot code used for scaling a given component.
  function automatic longint pivot_of(logic chroma, int piv_y, int piv_c);
    return chroma ? longint'(piv_c) : longint'(piv_y);
  endfunction

endpackage

// File: rtl/vproc_mul_stage.sv
module vproc_mul_stage
  import vproc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int GW    = 15,
  parameter int LOW   = 13,
  parameter int COW   = 12,
  parameter int OW    = 13,
  parameter int PW    = 27,
  parameter int PIV_Y = 64,
  parameter int PIV_C = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  vp_tag_t               tag_in,
  input  logic [DW-1:0]         sample_in,
  input  logic [GW-1:0]         luma_gain,
  input  logic [GW-1:0]         chroma_gain,
  input  logic signed [LOW-1:0] luma_ofs,
  input  logic signed [COW-1:0] chroma_ofs,
  output vp_tag_t               tag_q,
  output logic [DW-1:0]         raw_q,
  output logic signed [PW-1:0]  prod_q,
  output logic signed [OW-1:0]  ofs_q
);

  longint diff_l;
  longint gain_l;
  longint prod_l;
  longint ofs_l;

  always_comb begin
    diff_l = longint'(sample_in) - pivot_of(tag_in.chroma, PIV_Y, PIV_C);
    gain_l = tag_in.chroma ? longint'(chroma_gain) : longint'(luma_gain);
    prod_l = diff_l * gain_l;
    ofs_l  = tag_in.chroma ? longint'(chroma_ofs) : longint'(luma_ofs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      raw_q  <= '0;
      prod_q <= '0;
      ofs_q  <= '0;
    end else begin
      tag_q  <= tag_in;
      raw_q  <= sample_in;
      prod_q <= PW'(prod_l);
      ofs_q  <= OW'(ofs_l);
    end
  end

endmodule

// File: rtl/vproc_add_stage.sv
module vproc_add_stage
  import vproc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int OW    = 13,
  parameter int PW    = 27,
  parameter int VW    = 18,
  parameter int PSH   = 11,
  parameter int QF    = 2,
  parameter int PIV_Y = 64,
  parameter int PIV_C = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vp_tag_t              tag_in,
  input  logic [DW-1:0]        raw_in,
  input  logic signed [PW-1:0] prod_in,
  input  logic signed [OW-1:0] ofs_in,
  output vp_tag_t              tag_q,
  output logic [DW-1:0]        raw_q,
  output logic signed [VW-1:0] val_q
);

  longint quarter_l;
  longint sum_l;
  longint whole_l;
  longint val_l;

  always_comb begin
    quarter_l = rnd_shr(longint'(prod_in), PSH);
    sum_l     = quarter_l + longint'(ofs_in);
    whole_l   = rnd_shr(sum_l, QF);
    val_l     = whole_l + pivot_of(tag_in.chroma, PIV_Y, PIV_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      raw_q <= '0;
      val_q <= '0;
    end else begin
      tag_q <= tag_in;
      raw_q <= raw_in;
      val_q <= VW'(val_l);
    end
  end

endmodule

// File: rtl/vproc_clip_stage.sv
module vproc_clip_stage
  import vproc_pkg::*;
#(
  parameter int DW        = 10,
  parameter int VW        = 18,
  parameter int LEG_Y_MIN = 'h040,
  parameter int LEG_Y_MAX = 'h3AC,
  parameter int LEG_C_MIN = 'h040,
  parameter int LEG_C_MAX = 'h3C0,
  parameter int RSV_MIN   = 'h004,
  parameter int RSV_MAX   = 'h3FB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vp_tag_t              tag_in,
  input  logic [DW-1:0]        raw_in,
  input  logic signed [VW-1:0] val_in,
  output logic                 valid_q,
  output logic                 chroma_q,
  output logic                 anc_q,
  output logic [DW-1:0]        sample_q,
  output logic                 lo_hit,
  output logic                 hi_hit
);

  longint lo_l;
  longint hi_l;
  longint v_l;
  logic [DW-1:0] sample_d;

  always_comb begin
    if (tag_in.legal) begin
      lo_l = tag_in.chroma ? longint'(LEG_C_MIN) : longint'(LEG_Y_MIN);
      hi_l = tag_in.chroma ? longint'(LEG_C_MAX) : longint'(LEG_Y_MAX);
    end else begin
      lo_l = longint'(RSV_MIN);
      hi_l = longint'(RSV_MAX);
    end
    v_l      = longint'(val_in);
    sample_d = tag_in.anc ? raw_in : DW'(clamp(v_l, lo_l, hi_l));
  end

  // Clip events, brought out for the checker.
  assign lo_hit = tag_in.valid && !tag_in.anc && (v_l < lo_l);
  assign hi_hit = tag_in.valid && !tag_in.anc && (v_l > hi_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      chroma_q <= 1'b0;
      anc_q    <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q  <= tag_in.valid;
      chroma_q <= tag_in.chroma;
      anc_q    <= tag_in.anc;
      sample_q <= sample_d;
    end
  end

endmodule

// File: rtl/vproc_gain_clip.sv
module vproc_gain_clip
  import vproc_pkg::*;
#(
  parameter int DW         = 10,
  parameter int GW         = 15,
  parameter int LOW        = 13,
  parameter int COW        = 12,
  parameter int UNITY_LOG2 = 13,
  parameter int QF         = 2,
  parameter int PIV_Y      = 'h040,
  parameter int PIV_C      = 'h200,
  parameter int LEG_Y_MIN  = 'h040,
  parameter int LEG_Y_MAX  = 'h3AC,
  parameter int LEG_C_MIN  = 'h040,
  parameter int LEG_C_MAX  = 'h3C0,
  parameter int RSV_MIN    = 'h004,
  parameter int RSV_MAX    = 'h3FB
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DW-1:0]         in_sample,
  input  logic                  in_chroma,
  input  logic                  in_anc,
  input  logic [GW-1:0]         luma_gain,
  input  logic [GW-1:0]         chroma_gain,
  input  logic signed [LOW-1:0] luma_ofs,
  input  logic signed [COW-1:0] chroma_ofs,
  input  logic                  legal_en,
  output logic                  out_valid,
  output logic [DW-1:0]         out_sample,
  output logic                  out_chroma,
  output logic                  out_anc
);

  localparam int OW  = (LOW > COW) ? LOW : COW;
  localparam int PW  = DW + GW + 2;
  localparam int PSH = UNITY_LOG2 - QF;
  localparam int VW  = PW - PSH + 2;

  vp_tag_t               tag0;
  vp_tag_t               tag1;
  vp_tag_t               tag2;
  logic [DW-1:0]         raw1;
  logic [DW-1:0]         raw2;
  logic signed [PW-1:0]  prod1;
  logic signed [OW-1:0]  ofs1;
  logic signed [VW-1:0]  val2;
  logic                  clip_lo_hit;
  logic                  clip_hi_hit;

  assign tag0 = '{valid: in_valid, chroma: in_chroma, anc: in_anc, legal: legal_en};

  vproc_mul_stage #(
    .DW(DW), .GW(GW), .LOW(LOW), .COW(COW), .OW(OW), .PW(PW),
    .PIV_Y(PIV_Y), .PIV_C(PIV_C)
  ) u_mul (
    .clk(clk), .rst_n(rst_n), .tag_in(tag0), .sample_in(in_sample),
    .luma_gain(luma_gain), .chroma_gain(chroma_gain),
    .luma_ofs(luma_ofs), .chroma_ofs(chroma_ofs),
    .tag_q(tag1), .raw_q(raw1), .prod_q(prod1), .ofs_q(ofs1)
  );

  vproc_add_stage #(
    .DW(DW), .OW(OW), .PW(PW), .VW(VW), .PSH(PSH), .QF(QF),
    .PIV_Y(PIV_Y), .PIV_C(PIV_C)
  ) u_add (
    .clk(clk), .rst_n(rst_n), .tag_in(tag1), .raw_in(raw1),
    .prod_in(prod1), .ofs_in(ofs1),
    .tag_q(tag2), .raw_q(raw2), .val_q(val2)
  );

  vproc_clip_stage #(
    .DW(DW), .VW(VW),
    .LEG_Y_MIN(LEG_Y_MIN), .LEG_Y_MAX(LEG_Y_MAX),
    .LEG_C_MIN(LEG_C_MIN), .LEG_C_MAX(LEG_C_MAX),
    .RSV_MIN(RSV_MIN), .RSV_MAX(RSV_MAX)
  ) u_clip (
    .clk(clk), .rst_n(rst_n), .tag_in(tag2), .raw_in(raw2), .val_in(val2),
    .valid_q(out_valid), .chroma_q(out_chroma), .anc_q(out_anc),
    .sample_q(out_sample), .lo_hit(clip_lo_hit), .hi_hit(clip_hi_hit)
  );

endmodule

// File: rtl/vproc_gain_clip_chk.sv
module vproc_gain_clip_chk #(
  parameter int DW         = 10,
  parameter int GW         = 15,
  parameter int LOW        = 13,
  parameter int COW        = 12,
  parameter int UNITY_LOG2 = 13,
  parameter int LEG_Y_MIN  = 'h040,
  parameter int LEG_Y_MAX  = 'h3AC,
  parameter int LEG_C_MIN  = 'h040,
  parameter int LEG_C_MAX  = 'h3C0,
  parameter int RSV_MIN    = 'h004,
  parameter int RSV_MAX    = 'h3FB
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [DW-1:0]         in_sample,
  input logic                  in_chroma,
  input logic                  in_anc,
  input logic [GW-1:0]         luma_gain,
  input logic [GW-1:0]         chroma_gain,
  input logic signed [LOW-1:0] luma_ofs,
  input logic signed [COW-1:0] chroma_ofs,
  input logic                  legal_en,
  input logic                  out_valid,
  input logic [DW-1:0]         out_sample,
  input logic                  out_chroma,
  input logic                  out_anc,
  input logic                  clip_lo_hit,
  input logic                  clip_hi_hit
);

  localparam int LOW_CEIL  = (LEG_Y_MIN > LEG_C_MIN) ? LEG_Y_MIN : LEG_C_MIN;
  localparam int HIGH_FLR  = (LEG_Y_MAX < LEG_C_MAX) ? LEG_Y_MAX : LEG_C_MAX;
  localparam int UNITY     = 1 << UNITY_LOG2;

  logic [1:0] age;
  logic       warm;
  int         sel_g;
  int         sel_o;
  int         win_lo;
  int         win_hi;
  logic       unity_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  always_comb begin
    sel_g  = in_chroma ? int'(chroma_gain) : int'(luma_gain);
    sel_o  = in_chroma ? int'(chroma_ofs) : int'(luma_ofs);
    win_lo = legal_en ? (in_chroma ? LEG_C_MIN : LEG_Y_MIN) : RSV_MIN;
    win_hi = legal_en ? (in_chroma ? LEG_C_MAX : LEG_Y_MAX) : RSV_MAX;
    unity_now = in_valid && !in_anc && (sel_g == UNITY) && (sel_o == 0)
                && (int'(in_sample) >= win_lo) && (int'(in_sample) <= win_hi);
  end

  AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)) && (out_chroma == $past(in_chroma, 3))
             && (out_anc == $past(in_anc, 3))); // R1

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !out_valid); // R1

  AST_UNITY_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(unity_now, 3)) |-> (out_sample == $past(in_sample, 3))); // R2

  AST_ANC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && out_anc) |-> (out_sample == $past(in_sample, 3))); // R9

  AST_LEGAL_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !out_anc && !out_chroma && $past(legal_en, 3))
      |-> (int'(out_sample) >= LEG_Y_MIN) && (int'(out_sample) <= LEG_Y_MAX)); // R6

  AST_LEGAL_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !out_anc && out_chroma && $past(legal_en, 3))
      |-> (int'(out_sample) >= LEG_C_MIN) && (int'(out_sample) <= LEG_C_MAX)); // R7

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_anc)
      |-> (int'(out_sample) >= RSV_MIN) && (int'(out_sample) <= RSV_MAX)); // R8

  AST_LOW_CLIP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    clip_lo_hit |=> (int'(out_sample) <= LOW_CEIL)); // R6

  AST_HIGH_CLIP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    clip_hi_hit |=> (int'(out_sample) >= HIGH_FLR)); // R7

endmodule

bind vproc_gain_clip vproc_gain_clip_chk #(
  .DW(DW), .GW(GW), .LOW(LOW), .COW(COW), .UNITY_LOG2(UNITY_LOG2),
  .LEG_Y_MIN(LEG_Y_MIN), .LEG_Y_MAX(LEG_Y_MAX),
  .LEG_C_MIN(LEG_C_MIN), .LEG_C_MAX(LEG_C_MAX),
  .RSV_MIN(RSV_MIN), .RSV_MAX(RSV_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .in_chroma(in_chroma), .in_anc(in_anc), .luma_gain(luma_gain),
  .chroma_gain(chroma_gain), .luma_ofs(luma_ofs), .chroma_ofs(chroma_ofs),
  .legal_en(legal_en), .out_valid(out_valid), .out_sample(out_sample),
  .out_chroma(out_chroma), .out_anc(out_anc),
  .clip_lo_hit(clip_lo_hit), .clip_hi_hit(clip_hi_hit)
);

// File: tb/sim_vproc_gain_clip.sv
module sim_vproc_gain_clip;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [9:0]        in_sample = '0;
  logic              in_chroma = 1'b0;
  logic              in_anc = 1'b0;
  logic [14:0]       luma_gain = 15'd8192;
  logic [14:0]       chroma_gain = 15'd8192;
  logic signed [12:0] luma_ofs = '0;
  logic signed [11:0] chroma_ofs = '0;
  logic              legal_en = 1'b1;
  logic              out_valid;
  logic [9:0]        out_sample;
  logic              out_chroma;
  logic              out_anc;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  localparam int UNITY = 8192;
  localparam int NS = 24;

  vproc_gain_clip u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chroma(in_chroma), .in_anc(in_anc), .luma_gain(luma_gain),
    .chroma_gain(chroma_gain), .luma_ofs(luma_ofs), .chroma_ofs(chroma_ofs),
    .legal_en(legal_en), .out_valid(out_valid), .out_sample(out_sample),
    .out_chroma(out_chroma), .out_anc(out_anc)
  );

  always #4 clk = ~clk;

  // Floor division written with integer division, not shifts.
  function automatic longint fdiv(longint a, longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  // Expected output built directly from the requirements.
  function automatic int model(int s, bit ch, bit an, int lg, int cg, int lof, int cof, bit leg);
    longint piv, d, q, t, r, v;
    int lo_w, hi_w;
    if (an) return s;
    piv = ch ? 512 : 64;
    d = s - piv;
    q = fdiv(d * (ch ? cg : lg) + 1024, 2048);
    t = q + (ch ? cof : lof);
    r = fdiv(t + 2, 4);
    v = r + piv;
    if (leg) begin lo_w = 64; hi_w = ch ? 960 : 940; end
    else begin lo_w = 4; hi_w = 1019; end
    if (v < lo_w) return lo_w;
    if (v > hi_w) return hi_w;
    return int'(v);
  endfunction

  task automatic chk(string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d (%h) expected %0d (%h)", what, got, got, exp, exp);
    end
  endtask

  task automatic put(bit v, int s, bit ch, bit an, int lg, int cg, int lof, int cof, bit leg);
    in_valid    = v;
    in_sample   = 10'(s);
    in_chroma   = ch;
    in_anc      = an;
    luma_gain   = 15'(lg);
    chroma_gain = 15'(cg);
    luma_ofs    = 13'(lof);
    chroma_ofs  = 12'(cof);
    legal_en    = leg;
  endtask

  // One sample through the pipe; result seen at the third falling edge after driving.
  task automatic single(string tag, int s, bit ch, bit an, int lg, int cg, int lof, int cof, bit leg);
    int exp;
    exp = model(s, ch, an, lg, cg, lof, cof, leg);
    @(negedge clk);
    put(1'b1, s, ch, an, lg, cg, lof, cof, leg);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " sample"}, int'(out_sample), exp);
  endtask

  task automatic t_reset();
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset out_sample", int'(out_sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first edge after reset out_valid", int'(out_valid), 0);
  endtask

  task automatic t_unity();
    single("R2 luma unity 0x100", 'h100, 0, 0, UNITY, 0, 0, 0, 1);
    single("R3 chroma unity 0x300", 'h300, 1, 0, 0, UNITY, 0, 0, 1);
    single("R3 chroma unity 0x040", 'h040, 1, 0, 0, UNITY, 0, 0, 1);
  endtask

  task automatic t_gain();
    single("R2 luma gain 2x", 'h100, 0, 0, 16384, UNITY, 0, 0, 1);
    single("R3 chroma gain 0.5x", 'h300, 1, 0, UNITY, 4096, 0, 0, 1);
    single("R3 chroma gain 0.5x below pivot", 'h100, 1, 0, UNITY, 4096, 0, 0, 1);
    single("R2 luma gain zero", 'h300, 0, 0, 0, UNITY, 0, 0, 1);
    single("R3 chroma gain zero", 'h080, 1, 0, UNITY, 0, 0, 0, 1);
    single("R2 luma gain max", 'h200, 0, 0, 32767, UNITY, 0, 0, 0);
    single("R5 luma +1.5 rounds up", 65, 0, 0, 12288, UNITY, 0, 0, 1);
    single("R5 chroma -1.5 rounds up", 511, 1, 0, UNITY, 12288, 0, 0, 1);
    single("R5 luma gain 8193 fine step", 'h3A0, 0, 0, 8193, UNITY, 0, 0, 1);
  endtask

  task automatic t_offset();
    single("R4 luma +4 quarters", 'h100, 0, 0, UNITY, UNITY, 4, 0, 1);
    single("R4 luma +2 quarters half up", 'h100, 0, 0, UNITY, UNITY, 2, 0, 1);
    single("R4 luma +1 quarter", 'h100, 0, 0, UNITY, UNITY, 1, 0, 1);
    single("R4 luma -2 quarters", 'h100, 0, 0, UNITY, UNITY, -2, 0, 1);
    single("R4 luma min offset", 'h3A0, 0, 0, UNITY, UNITY, -4095, 0, 0);
    single("R4 luma max offset", 'h100, 0, 0, UNITY, UNITY, 4095, 0, 0);
    single("R4 chroma min offset", 'h300, 1, 0, UNITY, UNITY, 0, -2047, 0);
    single("R4 chroma max offset", 'h200, 1, 0, UNITY, UNITY, 0, 2047, 0);
  endtask

  task automatic t_legal_on();
    single("R6 luma top clip", 'h3FF, 0, 0, UNITY, UNITY, 0, 0, 1);
    single("R6 luma bottom clip", 'h000, 0, 0, UNITY, UNITY, 0, 0, 1);
    single("R6 luma edge 0x3AC kept", 'h3AC, 0, 0, UNITY, UNITY, 0, 0, 1);
    single("R7 chroma top clip", 'h3F0, 1, 0, UNITY, UNITY, 0, 0, 1);
    single("R7 chroma bottom clip", 'h010, 1, 0, UNITY, UNITY, 0, 0, 1);
    single("R7 chroma 0x3B0 above luma limit kept", 'h3B0, 1, 0, UNITY, UNITY, 0, 0, 1);
  endtask

  task automatic t_legal_off();
    single("R8 luma top reserved clip", 'h3FF, 0, 0, UNITY, UNITY, 0, 0, 0);
    single("R8 luma bottom reserved clip", 'h000, 0, 0, UNITY, UNITY, 0, 0, 0);
    single("R8 chroma bottom reserved clip", 'h002, 1, 0, UNITY, UNITY, 0, 0, 0);
    single("R8 luma 0x3C0 kept", 'h3C0, 0, 0, UNITY, UNITY, 0, 0, 0);
    single("R8 chroma 0x010 kept", 'h010, 1, 0, UNITY, UNITY, 0, 0, 0);
  endtask

  task automatic t_anc();
    single("R9 anc 0x3FF untouched", 'h3FF, 0, 1, 0, 0, 4095, 2047, 1);
    single("R9 anc 0x000 untouched", 'h000, 1, 1, 32767, 32767, -4095, -2047, 1);
    single("R9 anc 0x3FF legal off", 'h3FF, 1, 1, 100, 9000, 5, -7, 0);
  endtask

  task automatic t_select();
    single("R10 chroma ignores luma controls", 'h2A0, 1, 0, 0, UNITY, 4095, 0, 1);
    single("R10 luma ignores chroma controls", 'h1C0, 0, 0, UNITY, 0, 0, -2047, 1);
  endtask

  // Back-to-back stream with gaps and controls changing every cycle.
  task automatic t_stream();
    int  s[NS];
    bit  v[NS];
    bit  ch[NS];
    bit  an[NS];
    int  ex[NS];
    for (int i = 0; i < NS; i++) begin
      int lg, cg, lof, cof;
      bit leg;
      s[i]  = (i * 157 + 33) % 1024;
      v[i]  = (i % 5) != 4;
      ch[i] = i[0];
      an[i] = (i % 7) == 3;
      lg    = (i * 2731 + 5000) % 32768;
      cg    = (i * 5113 + 700) % 32768;
      lof   = ((i * 911) % 8191) - 4095;
      cof   = ((i * 433) % 4095) - 2047;
      leg   = (i % 3) != 0;
      ex[i] = model(s[i], ch[i], an[i], lg, cg, lof, cof, leg);
    end
    for (int k = 0; k < NS + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk($sformatf("R1 stream valid %0d", k - 3), int'(out_valid), int'(v[k-3]));
        chk($sformatf("R1 stream anc flag %0d", k - 3), int'(out_anc), int'(an[k-3]));
        chk($sformatf("R1 stream chroma flag %0d", k - 3), int'(out_chroma), int'(ch[k-3]));
        if (v[k-3])
          chk($sformatf("R11 stream sample %0d", k - 3), int'(out_sample), ex[k-3]);
      end
      if (k < NS) begin
        put(v[k], s[k], ch[k], an[k],
            (k * 2731 + 5000) % 32768, (k * 5113 + 700) % 32768,
            ((k * 911) % 8191) - 4095, ((k * 433) % 4095) - 2047, (k % 3) != 0);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_unity();
    t_gain();
    t_offset();
    t_legal_on();
    t_legal_off();
    t_anc();
    t_select();
    t_stream();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule